// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit rearranges the elements of one vector register under the control of a mask that carries one bit per element. It has two operations. In compress mode, every element whose mask bit is set moves down into the lowest free output slot. The elements keep their relative order, and the unit reports how many were moved. In expand mode, the unit reads consecutive elements from the bottom of a packed source and drops them into the slots whose mask bit is set. Every other slot keeps the destination value that was supplied with the command.

A command is issued by raising `start_i` while the unit is idle. On that edge the unit captures the source, the destination, the mask, the length and the operation. It then walks the active elements one per clock. When it has finished, it raises `done_o` for a single cycle. The result and the packed length stay on the outputs until the next command is accepted. This makes the unit suitable for building density-time conditionals and general selection sequences.

Top module: `vmask_pack_unit`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, every bit of `result_o` is 0 and `packed_len_o` is 0.
- R2: With `op_i`=0 (compress), the elements at positions with a set mask bit appear in output slots 0, 1, 2, … in ascending source order. Element i occupies bits [i*ELEM_W +: ELEM_W] in every vector port.
- R3: In both modes, `packed_len_o` at completion equals the number of set mask bits among positions below the effective length.
- R4: After a compress, output slots at or above the packed length hold the corresponding `dst_i` value captured at the start.
- R5: With `op_i`=1 (expand), the k-th source element (counting from slot 0) is written to the position of the k-th set mask bit within the effective length.
- R6: After an expand, positions whose mask bit is clear hold the captured `dst_i` value.
- R7: Mask bits at or above the effective length have no effect. Result positions at or above that length hold the captured `dst_i` value, and those bits are not counted in the packed length.
- R8: Call the edge that accepts a start edge 0, and let L be the effective length. `busy_o` is high in the cycles following edges 0 to L-1. `done_o` is high only in the cycle following edge L, and for exactly one cycle. When L=0, `busy_o` stays low and `done_o` follows edge 0.
- R9: `start_i` is ignored while `busy_o` or `done_o` is high. From completion until the next accepted start, `result_o` and `packed_len_o` hold their values.
- R10: A `vlen_i` value above VLEN_MAX is treated as VLEN_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command request, accepted only while idle |
| op_i | input | 1 | 0 = compress, 1 = expand |
| vlen_i | input | LEN_W | Number of active elements |
| mask_i | input | VLEN_MAX | One select bit per element |
| src_i | input | VLEN_MAX*ELEM_W | Source vector |
| dst_i | input | VLEN_MAX*ELEM_W | Prior destination vector |
| busy_o | output | 1 | Elements are being processed |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | VLEN_MAX*ELEM_W | Resulting vector |
| packed_len_o | output | LEN_W | Count of selected elements |

## Verification
A wrong pack pointer shows up directly at the ports. It puts an element in the wrong slot, or drops one, in `result_o`, and it gives a wrong `packed_len_o`. Both are visible in the `done_o` cycle of that same command. A wrong element index or length limit shows up a cycle earlier or later. It moves the `done_o` pulse or the `busy_o` window, and the bench compares both on every clock, so the error is caught in the cycle it first differs. Leaked mask bits and a failure to hold values between commands are exposed by commands that use short lengths with high mask bits set, and by idle cycles checked after completion.

// File: rtl/vmpk_pkg.sv
package vmpk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } vmpk_state_e;

  typedef enum logic {
    OP_COMPRESS = 1'b0,
    OP_EXPAND   = 1'b1
  } vmpk_op_e;
endpackage

// File: rtl/vmpk_ctrl.sv
module vmpk_ctrl
  import vmpk_pkg::*;
#(
  parameter int VLEN_MAX = 8,
  parameter int LEN_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] vlen_i,
  output logic             load_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o
);
  vmpk_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [LEN_W-1:0] lim_q, lim_d;
  logic [LEN_W-1:0] vlen_eff;
  logic             last;

  // lengths beyond capacity clamp (R10)
  assign vlen_eff = (vlen_i > LEN_W'(VLEN_MAX)) ? LEN_W'(VLEN_MAX) : vlen_i;
  assign last     = ((LEN_W'(idx_q) + LEN_W'(1)) == lim_q);
  assign load_o   = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    lim_d   = lim_q;
    case (state_q)
      ST_IDLE: if (start_i) begin
        idx_d   = '0;
        lim_d   = vlen_eff;
        state_d = (vlen_eff == '0) ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        idx_d = idx_q + IDX_W'(1);
        if (last) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o || step_o) idx_q <= idx_d;
      if (load_o) lim_q <= lim_d;
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/vmpk_pack_dp.sv
module vmpk_pack_dp
  import vmpk_pkg::*;
#(
  parameter int VLEN_MAX = 8,
  parameter int ELEM_W   = 8,
  parameter int LEN_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic                       step_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       op_i,
  input  logic [VLEN_MAX-1:0]        mask_i,
  input  logic [VLEN_MAX*ELEM_W-1:0] src_i,
  input  logic [VLEN_MAX*ELEM_W-1:0] dst_i,
  output logic [VLEN_MAX*ELEM_W-1:0] result_o,
  output logic [LEN_W-1:0]           count_o
);
  logic [ELEM_W-1:0] src_q [VLEN_MAX];
  logic [ELEM_W-1:0] res_q [VLEN_MAX];
  logic [ELEM_W-1:0] res_d [VLEN_MAX];
  logic [VLEN_MAX-1:0] mask_q;
  vmpk_op_e            op_q;
  logic [LEN_W-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0]    pk_idx, wr_addr;
  logic [ELEM_W-1:0]   wr_data;
  logic                hit;

  assign hit     = step_i && mask_q[idx_i];
  assign pk_idx  = cnt_q[IDX_W-1:0];
  assign wr_addr = (op_q == OP_COMPRESS) ? pk_idx : idx_i;
  assign wr_data = (op_q == OP_COMPRESS) ? src_q[idx_i] : src_q[pk_idx];
  assign cnt_d   = load_i ? '0 : cnt_q + LEN_W'(hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      op_q   <= OP_COMPRESS;
      cnt_q  <= '0;
    end else begin
      if (load_i) begin
        mask_q <= mask_i;
        op_q   <= vmpk_op_e'(op_i);
      end
      if (load_i || hit) cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < VLEN_MAX; g++) begin : g_slot
    always_comb begin
      res_d[g] = res_q[g];
      if (load_i)
        res_d[g] = dst_i[g*ELEM_W +: ELEM_W];
      else if (hit && (wr_addr == IDX_W'(g)))
        res_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= '0;
        res_q[g] <= '0;
      end else begin
        if (load_i) src_q[g] <= src_i[g*ELEM_W +: ELEM_W];
        if (load_i || hit) res_q[g] <= res_d[g];
      end
    end

    assign result_o[g*ELEM_W +: ELEM_W] = res_q[g];
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/vmask_pack_unit.sv
module vmask_pack_unit #(
  parameter int ELEM_W   = 8,
  parameter int VLEN_MAX = 8,
  parameter int LEN_W    = $clog2(VLEN_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       op_i,
  input  logic [LEN_W-1:0]           vlen_i,
  input  logic [VLEN_MAX-1:0]        mask_i,
  input  logic [VLEN_MAX*ELEM_W-1:0] src_i,
  input  logic [VLEN_MAX*ELEM_W-1:0] dst_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [VLEN_MAX*ELEM_W-1:0] result_o,
  output logic [LEN_W-1:0]           packed_len_o
);
  localparam int IDX_W = (VLEN_MAX > 1) ? $clog2(VLEN_MAX) : 1;

  logic             load, step;
  logic [IDX_W-1:0] idx;

  vmpk_ctrl #(
    .VLEN_MAX(VLEN_MAX), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .load_o(load), .step_o(step), .idx_o(idx),
    .busy_o(busy_o), .done_o(done_o)
  );

  vmpk_pack_dp #(
    .VLEN_MAX(VLEN_MAX), .ELEM_W(ELEM_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step), .idx_i(idx),
    .op_i(op_i), .mask_i(mask_i), .src_i(src_i), .dst_i(dst_i),
    .result_o(result_o), .count_o(packed_len_o)
  );
endmodule

// File: rtl/vmask_pack_unit_chk.sv
module vmask_pack_unit_chk #(
  parameter int ELEM_W   = 8,
  parameter int VLEN_MAX = 8,
  parameter int LEN_W    = $clog2(VLEN_MAX + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start_i,
  input logic                       op_i,
  input logic [LEN_W-1:0]           vlen_i,
  input logic [VLEN_MAX-1:0]        mask_i,
  input logic [VLEN_MAX*ELEM_W-1:0] src_i,
  input logic [VLEN_MAX*ELEM_W-1:0] dst_i,
  input logic                       busy_o,
  input logic                       done_o,
  input logic [VLEN_MAX*ELEM_W-1:0] result_o,
  input logic [LEN_W-1:0]           packed_len_o
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o) |=> (busy_o || done_o));

  assert_busy_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i && !done_o));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && !start_i) |=> ($stable(result_o) && $stable(packed_len_o)));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> ($stable(result_o) && $stable(packed_len_o)));

  assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (packed_len_o <= LEN_W'(VLEN_MAX)));
endmodule

bind vmask_pack_unit vmask_pack_unit_chk #(
  .ELEM_W(ELEM_W), .VLEN_MAX(VLEN_MAX), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/vmask_pack_unit_tb.sv
module vmask_pack_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int W = 8;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic op_i = 1'b0;
  logic [LW-1:0] vlen_i = '0;
  logic [N-1:0] mask_i = '0;
  logic [N*W-1:0] src_i = '0;
  logic [N*W-1:0] dst_i = '0;
  logic busy_o, done_o;
  logic [N*W-1:0] result_o;
  logic [LW-1:0] packed_len_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  vmask_pack_unit #(.ELEM_W(W), .VLEN_MAX(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .vlen_i(vlen_i),
    .mask_i(mask_i), .src_i(src_i), .dst_i(dst_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o), .packed_len_o(packed_len_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic run_op(input bit op, input int vlen, input logic [N-1:0] mask,
                        input logic [N*W-1:0] src, input logic [N*W-1:0] dst,
                        input bit junk, input string req);
    int veff;
    logic [W-1:0] picked[$];
    logic [N*W-1:0] exp_res;
    int exp_len;
    int k;
    veff = (vlen > N) ? N : vlen;
    exp_res = dst;
    k = 0;
    for (int i = 0; i < veff; i++) begin
      if (mask[i]) begin
        if (op == 1'b0) picked.push_back(src[i*W +: W]);
        else exp_res[i*W +: W] = src[k*W +: W];
        k++;
      end
    end
    exp_len = k;
    for (int i = 0; i < picked.size(); i++) exp_res[i*W +: W] = picked[i];

    @(negedge clk);
    start_i = 1'b1; op_i = op; vlen_i = LW'(vlen); mask_i = mask;
    src_i = src; dst_i = dst;
    @(posedge clk);
    for (int j = 0; j <= veff; j++) begin
      @(negedge clk);
      check(busy_o == (j < veff), "R8", $sformatf("busy step %0d", j),
            {63'd0, busy_o}, {63'd0, (j < veff)});
      check(done_o == (j == veff), "R8", $sformatf("done step %0d", j),
            {63'd0, done_o}, {63'd0, (j == veff)});
      if (j == veff) begin
        check(result_o == exp_res, req, "result", result_o, exp_res);
        check(packed_len_o == LW'(exp_len), "R3", "packed length",
              {60'd0, packed_len_o}, 64'(exp_len));
      end
      if (junk && j < veff - 1) begin
        start_i = 1'b1; op_i = ~op; vlen_i = LW'(N);
        mask_i = ~mask; src_i = ~src; dst_i = ~dst;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    @(negedge clk);
    check(!busy_o && !done_o, "R8", "idle after done",
          {62'd0, busy_o, done_o}, 64'd0);
    check(result_o == exp_res, "R9", "result held after done", result_o, exp_res);
    check(packed_len_o == LW'(exp_len), "R9", "length held after done",
          {60'd0, packed_len_o}, 64'(exp_len));
  endtask

  localparam logic [N*W-1:0] SRC_A = 64'hA7A6A5A4A3A2A1A0;
  localparam logic [N*W-1:0] SRC_P = 64'h1716151413121110;
  localparam logic [N*W-1:0] DST_D = 64'hD7D6D5D4D3D2D1D0;

  initial begin
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o, "R1", "flags in reset", {62'd0, busy_o, done_o}, 64'd0);
    check(result_o == '0, "R1", "result in reset", result_o, 64'd0);
    check(packed_len_o == '0, "R1", "length in reset", {60'd0, packed_len_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && result_o == '0, "R1", "state after release",
          result_o, 64'd0);

    // R2 R4: select A1, A4, A5, A7 into slots 0..3
    run_op(1'b0, 8, 8'b1011_0010, SRC_A, DST_D, 1'b0, "R2/R4");
    // R5 R6: packed 10..13 land at 1,4,5,7
    run_op(1'b1, 8, 8'b1011_0010, SRC_P, DST_D, 1'b0, "R5/R6");
    run_op(1'b0, 8, 8'hFF, SRC_A, DST_D, 1'b0, "R2");
    run_op(1'b0, 8, 8'h00, SRC_A, DST_D, 1'b0, "R4");
    run_op(1'b1, 8, 8'h00, SRC_P, DST_D, 1'b0, "R6");
    run_op(1'b1, 8, 8'hFF, SRC_P, DST_D, 1'b0, "R5");
    // R7: high mask bits beyond the length
    run_op(1'b0, 5, 8'hFF, SRC_A, DST_D, 1'b0, "R7");
    run_op(1'b1, 3, 8'hF5, SRC_P, DST_D, 1'b0, "R7");
    // R8: zero length
    run_op(1'b0, 0, 8'hFF, SRC_A, DST_D, 1'b0, "R8");
    // R10: length clamp
    run_op(1'b0, 12, 8'b0110_1001, SRC_A, DST_D, 1'b0, "R10");
    run_op(1'b1, 15, 8'b1100_0011, SRC_P, DST_D, 1'b0, "R10");
    // R9: start held high with other inputs while busy
    run_op(1'b0, 8, 8'b0101_0110, SRC_A, DST_D, 1'b1, "R9");
    run_op(1'b1, 6, 8'b0011_1010, SRC_P, DST_D, 1'b1, "R9");
    for (int t = 0; t < 24; t++) begin
      logic [31:0] a, b, c;
      a = rnd(); b = rnd(); c = rnd();
      run_op(a[0], int'(a[11:8]) % 10, b[7:0], {rnd(), rnd()}, {c, rnd()},
             a[1], a[0] ? "R5/R6" : "R2/R4");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule